// File: doc/BRIEF.md
# Raster line interrupt generator

This block gives a CPU an interrupt that is locked to the video raster. It counts transitions on the horizontal sync line and raises an interrupt each time a programmed number of transitions has gone by. Both the rising and the falling edge of horizontal sync count. Any change on vertical sync restarts the count, so the interrupt points land in the same places on every frame.

The interrupt stays pending until the CPU acknowledges it through a write to the mode register. The acknowledge clears only the pending flag. It does not disturb the count, so the next interrupt arrives at its usual place in the raster. A configuration page lets software set the terminal count. It also lets software switch the count source from horizontal sync transitions to a synchronous clock-enable tick. The sync inputs are asynchronous, and the block synchronizes them internally.

Top module: `raster_irq`

## Requirements
- R1: After reset `irq` is 0, the count is 0, the terminal count is 26 and the count source is horizontal sync.
- R2: With the source set to horizontal sync, every change of `hsync_async` in either direction advances the count by one. Each input change must be held for at least three clock cycles. A terminal count reached by an input change shows on `irq` at the third rising clock edge after the change.
- R3: When an advance would bring the count to the terminal count, the count is set back to 0 and keeps running, and `irq` is set. A terminal count of 0 means 256 advances.
- R4: Any change of `vsync_async` sets the count back to 0. If a vertical-sync change and a counted event are seen in the same cycle, the vertical-sync reset wins and no interrupt is raised.
- R5: An `io_wr` cycle with `io_addr[15:8]` = 0x7F and `io_wdata[4]` = 1 clears `irq` at the next clock edge. The low address byte is ignored. A write with `io_wdata[4]` = 0 has no effect, and the acknowledge leaves the count unchanged.
- R6: `irq` is a level that stays 1 until it is cleared. A further terminal count while it is pending keeps it at 1. A terminal count in the same cycle as an acknowledge also leaves it at 1.
- R7: An `io_wr` cycle with `io_addr[15:8]` = 0x7E and `io_addr[0]` = 0 loads the terminal count from `io_wdata`. With `io_addr[0]` = 1, it loads the source select from `io_wdata[0]`: 0 selects horizontal sync, 1 selects the tick.
- R8: With the source set to tick, each clock cycle with `tick_en` high advances the count and horizontal sync changes are ignored. A terminal count reached this way shows on `irq` one clock edge later.
- R9: Writes whose `io_addr[15:8]` is neither 0x7F nor 0x7E change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_async | input | 1 | Horizontal sync, asynchronous |
| vsync_async | input | 1 | Vertical sync, asynchronous |
| tick_en | input | 1 | Synchronous count tick for the internal source |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| irq | output | 1 | Interrupt request, level, active high |

## Verification
The bench targets the acknowledge placed in the middle of a count. A design that reloads the counter on acknowledge would put the next interrupt late. The bench also sends a vertical-sync change in the same cycle as a horizontal edge. A design that lets the count win there would come out one interrupt early. It drives a terminal count and an acknowledge into the same cycle, and there a set-loses design would drop an interrupt. It checks the terminal count of 0, which must behave as 256. A wrong design would fire at once or never. It also checks that horizontal edges are ignored in tick mode and that writes to foreign pages have no effect. In both cases a loose decoder or source mux would shift the interrupt point.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

  typedef enum logic {
    SRC_HSYNC = 1'b0,
    SRC_TICK  = 1'b1
  } src_sel_e;

  typedef struct packed {
    logic ack;
    logic tc_we;
    logic ctl_we;
  } io_dec_t;

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic chg
);
  logic [STAGES-1:0] stage_q;
  logic              last_q;

  generate
    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= 1'b0;
          else     stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= stage_q[STAGES-1];
  end

  assign chg = stage_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/io_regs.sv
module io_regs
  import raster_irq_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter int          TC_RESET  = 26,
  parameter logic [7:0]  MODE_PAGE = 8'h7F,
  parameter logic [7:0]  CFG_PAGE  = 8'h7E,
  parameter int          ACK_BIT   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_wr,
  input  logic [15:0]      io_addr,
  input  logic [7:0]       io_wdata,
  output logic             ack,
  output logic [CNT_W-1:0] tc_q,
  output src_sel_e         src_q
);
  io_dec_t dec;
  logic    page_mode;
  logic    page_cfg;

  assign page_mode = io_addr[15:8] == MODE_PAGE;
  assign page_cfg  = io_addr[15:8] == CFG_PAGE;

  always_comb begin
    dec        = '0;
    dec.ack    = io_wr && page_mode && io_wdata[ACK_BIT];
    dec.tc_we  = io_wr && page_cfg && !io_addr[0];
    dec.ctl_we = io_wr && page_cfg &&  io_addr[0];
  end

  assign ack = dec.ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q  <= CNT_W'(TC_RESET);
      src_q <= SRC_HSYNC;
    end else begin
      if (dec.tc_we)  tc_q  <= CNT_W'(io_wdata);
      if (dec.ctl_we) src_q <= io_wdata[0] ? SRC_TICK : SRC_HSYNC;
    end
  end
endmodule

// File: rtl/line_counter.sv
module line_counter
  import raster_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_chg,
  input  logic             vs_chg,
  input  logic             tick_en,
  input  src_sel_e         src,
  input  logic [CNT_W-1:0] tc,
  output logic             hit,
  output logic [CNT_W-1:0] cnt_q
);
  logic             step;
  logic [CNT_W-1:0] cnt_inc;

  assign step    = (src == SRC_TICK) ? tick_en : hs_chg;
  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = step && !vs_chg && (cnt_inc == tc);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (vs_chg) cnt_q <= '0;
    else if (hit)    cnt_q <= '0;
    else if (step)   cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/raster_irq.sv
module raster_irq
  import raster_irq_pkg::*;
#(
  parameter int         CNT_W       = 8,
  parameter int         TC_RESET    = 26,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MODE_PAGE   = 8'h7F,
  parameter logic [7:0] CFG_PAGE    = 8'h7E,
  parameter int         ACK_BIT     = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hsync_async,
  input  logic        vsync_async,
  input  logic        tick_en,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  output logic        irq
);
  logic             hs_chg;
  logic             vs_chg;
  logic             ack;
  logic             hit;
  logic [CNT_W-1:0] tc_q;
  logic [CNT_W-1:0] cnt_q;
  src_sel_e         src_q;
  logic             pend_q;

  sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst(rst), .async_in(hsync_async), .chg(hs_chg));

  sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
    .clk(clk), .rst(rst), .async_in(vsync_async), .chg(vs_chg));

  io_regs #(
    .CNT_W(CNT_W), .TC_RESET(TC_RESET), .MODE_PAGE(MODE_PAGE),
    .CFG_PAGE(CFG_PAGE), .ACK_BIT(ACK_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .ack(ack), .tc_q(tc_q), .src_q(src_q));

  line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .hs_chg(hs_chg), .vs_chg(vs_chg),
    .tick_en(tick_en), .src(src_q), .tc(tc_q), .hit(hit), .cnt_q(cnt_q));

  // a new terminal count outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst)      pend_q <= 1'b0;
    else if (hit) pend_q <= 1'b1;
    else if (ack) pend_q <= 1'b0;
  end

  assign irq = pend_q;
endmodule

// File: rtl/raster_irq_checker.sv
module raster_irq_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             ack,
  input logic             hit,
  input logic             vs_chg,
  input logic             hs_chg,
  input logic             tick_en,
  input logic [CNT_W-1:0] cnt
);
  a_r4_vsync_restart: assert property (@(posedge clk) disable iff (rst)
    vs_chg |=> cnt == '0);

  a_r4_vsync_blocks_hit: assert property (@(posedge clk) disable iff (rst)
    vs_chg |-> !hit);

  a_r3_hit_reload: assert property (@(posedge clk) disable iff (rst)
    hit |=> cnt == '0);

  a_r3_hit_sets_irq: assert property (@(posedge clk) disable iff (rst)
    hit |=> irq);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !hit) |=> !irq);

  a_r5_ack_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (ack && !vs_chg && !hs_chg && !tick_en) |=> $stable(cnt));

  a_r6_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> irq);

  a_r6_no_spurious_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(hit));
endmodule

bind raster_irq raster_irq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .ack(ack), .hit(hit),
  .vs_chg(vs_chg), .hs_chg(hs_chg), .tick_en(tick_en), .cnt(cnt_q));

// File: tb/raster_irq_test.sv
`timescale 1ns/1ps
module raster_irq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync = 1'b0;
  logic        vsync = 1'b0;
  logic        tick_en = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        irq;

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    done = 0;

  always #2.5 clk = ~clk;

  raster_irq uut (
    .clk(clk), .rst(rst), .hsync_async(hsync), .vsync_async(vsync),
    .tick_en(tick_en), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .irq(irq));

  // behavioural reference: input delay queues, integer count, pending bit
  int q_hs[$];
  int q_vs[$];
  int m_cnt, m_tc, m_src, m_irq;

  always @(posedge clk) begin
    int hs_ev, vs_ev, step, hitm, ackm, nxt;
    if (rst) begin
      q_hs = '{0, 0, 0};
      q_vs = '{0, 0, 0};
      m_cnt = 0; m_tc = 26; m_src = 0; m_irq = 0;
    end else begin
      hs_ev = (q_hs[1] != q_hs[0]);
      vs_ev = (q_vs[1] != q_vs[0]);
      void'(q_hs.pop_front()); q_hs.push_back(int'(hsync));
      void'(q_vs.pop_front()); q_vs.push_back(int'(vsync));
      step = m_src ? int'(tick_en) : hs_ev;
      ackm = io_wr && io_addr[15:8] == 8'h7F && io_wdata[4];
      hitm = 0;
      if (vs_ev) m_cnt = 0;
      else if (step) begin
        nxt = (m_cnt + 1) % 256;
        if (nxt == m_tc) begin hitm = 1; m_cnt = 0; end
        else m_cnt = nxt;
      end
      if (hitm) m_irq = 1;
      else if (ackm) m_irq = 0;
      if (io_wr && io_addr[15:8] == 8'h7E) begin
        if (io_addr[0]) m_src = io_wdata[0];
        else            m_tc = io_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq !== m_irq[0]) begin
        errors++;
        $display("FAIL %s per-cycle irq: actual %b expected %0d at %0t", phase, irq, m_irq, $time);
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic hs_toggle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) hsync = ~hsync;
      repeat (3) @(negedge clk);
    end
    settle();
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_addr = '0; io_wdata = '0;
  endtask

  task automatic ack_irq();
    io_write(16'h7F00, 8'h10);
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", irq, 1'b0);

    phase = "R2";
    hs_toggle(25);  chk("R2 25 transitions no irq", irq, 1'b0);
    phase = "R3";
    hs_toggle(1);   chk("R3 26th transition irq", irq, 1'b1);

    phase = "R6";
    hs_toggle(26);  chk("R6 second terminal while pending", irq, 1'b1);
    phase = "R5";
    io_write(16'h7F00, 8'h00); settle();
    chk("R5 bit4 clear write ignored", irq, 1'b1);
    io_write(16'h7F5A, 8'h10); settle();
    chk("R5 ack with any low byte clears", irq, 1'b0);

    hs_toggle(10); ack_irq(); hs_toggle(15);
    chk("R5 ack keeps count, not yet", irq, 1'b0);
    hs_toggle(1);
    chk("R5 ack keeps count, fires at 26", irq, 1'b1);
    ack_irq();

    phase = "R4";
    hs_toggle(20);
    @(negedge clk) vsync = ~vsync;
    settle();
    hs_toggle(25); chk("R4 vsync restart, 25 after", irq, 1'b0);
    hs_toggle(1);  chk("R4 vsync restart, 26 after", irq, 1'b1);
    ack_irq();
    hs_toggle(20);
    @(negedge clk) begin hsync = ~hsync; vsync = ~vsync; end
    settle();
    hs_toggle(25); chk("R4 vsync wins same cycle, 25 after", irq, 1'b0);
    hs_toggle(1);  chk("R4 vsync wins same cycle, 26 after", irq, 1'b1);
    ack_irq();

    phase = "R7";
    io_write(16'h7E00, 8'd3); settle();
    hs_toggle(2); chk("R7 tc 3, two transitions", irq, 1'b0);
    hs_toggle(1); chk("R7 tc 3, third transition", irq, 1'b1);
    ack_irq();
    phase = "R3";
    io_write(16'h7E00, 8'd0); settle();
    hs_toggle(255); chk("R3 tc 0, 255 transitions", irq, 1'b0);
    hs_toggle(1);   chk("R3 tc 0 means 256", irq, 1'b1);
    ack_irq();

    phase = "R8";
    io_write(16'h7E00, 8'd5);
    io_write(16'h7E01, 8'h01); settle();
    hs_toggle(6); chk("R8 hsync ignored in tick mode", irq, 1'b0);
    @(negedge clk) tick_en = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b0; settle();
    chk("R8 four ticks", irq, 1'b0);
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    settle();
    chk("R8 fifth tick fires", irq, 1'b1);

    phase = "R9";
    io_write(16'h7D00, 8'hFF);
    io_write(16'hFF00, 8'h10);
    io_write(16'h7D01, 8'h00); settle();
    chk("R9 foreign page writes ignored", irq, 1'b1);
    ack_irq();
    @(negedge clk) tick_en = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b0; settle();
    chk("R9 source and tc unchanged", irq, 1'b0);
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    settle();
    chk("R9 source and tc unchanged, fires", irq, 1'b1);

    phase = "R6";
    io_write(16'h7E00, 8'd1); settle();
    @(negedge clk) tick_en = 1'b1;
    io_write(16'h7F00, 8'h10);
    @(negedge clk);
    chk("R6 terminal count beats same-cycle ack", irq, 1'b1);
    tick_en = 1'b0;
    ack_irq();
    chk("R6 ack after ticks stop clears", irq, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule